// File: doc/BRIEF.md
# Host Configuration Port Bridge

This block sits in a host bridge. It turns processor I/O accesses to two fixed doubleword ports into configuration cycles on the local bus. The address port is at 0CF8h–0CFBh and the data port is at 0CFCh–0CFFh. A full 32-bit write to the address port loads a selector register. The register holds an enable flag, a bus number, a device number, a function number and a doubleword register index.

A later access to the data port uses that register to build an address-phase pattern and a command code. The bridge then hands both to an external bus timing engine through a one-cycle start pulse, and waits for its done strobe. If the selected bus number equals the bridge's own bus, the block builds a local (Type 0) pattern. In that pattern the device number is decoded to a single high address line that serves as the chip-select. Any other bus number gives a forwarded (Type 1) pattern for downstream bridges.

Accesses the bridge does not claim are flagged as ordinary I/O, and the host gets a one-cycle acknowledge for every request it makes.

Top module: `cfg_port_bridge`

## Requirements
- R1: A write with all four byte enables (host_be = 1111) to dword address 0CF8h>>2 loads the selector. Field positions are: enable bit 31, bus 23:16, device 15:11, function 10:8, register 7:2. A full read of that address returns the selector with bits 30:24 and 1:0 as zero. Each of these accesses is acknowledged one cycle after the request.
- R2: Two kinds of access are acknowledged with host_passthru = 1 and change nothing: an access to the address port with fewer than four byte enables, and an access to any address other than the two ports.
- R3: When the enable bit is clear, a data-port read returns FFFFFFFFh and a data-port write is dropped. In both cases no bus cycle starts, and the acknowledge follows one cycle after the request.
- R4: When the bus field equals bridge_bus, the cycle address has exactly one bit set in 31:11, at bit 11+device. Function goes in 10:8, register in 7:2, and 1:0 is 00.
- R5: When the bus field differs from bridge_bus, the cycle address copies selector bits 23:2 unchanged. Bits 31:24 are zero and bits 1:0 are 01.
- R6: The command code is 1010 for a data-port read and 1011 for a data-port write.
- R7: A local cycle with a device number above 20 is a master abort. No bus cycle starts, reads return FFFFFFFFh, and the acknowledge follows one cycle after the request. A forwarded cycle is never aborted for its device number.
- R8: cyc_start is a single-cycle pulse in the cycle after the request. cyc_be and cyc_wdata equal the host byte enables and write data. Address, command, enables and data stay stable until cyc_done.
- R9: The acknowledge comes one cycle after cyc_done is sampled high. On a read, host_rdata carries the cyc_rdata value sampled with cyc_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bridge_bus | input | 8 | Bus number of the bridge's own local bus |
| host_req | input | 1 | One-cycle host access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_dw_addr | input | 14 | I/O doubleword address (I/O address bits 15:2) |
| host_be | input | 4 | Byte lanes accessed within the doubleword |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | One-cycle completion strobe |
| host_passthru | output | 1 | Access not claimed, handle as ordinary I/O (valid with ack) |
| host_rdata | output | 32 | Read data (valid with ack) |
| cyc_start | output | 1 | One-cycle start pulse to the bus timing engine |
| cyc_cmd | output | 4 | Configuration command code |
| cyc_addr | output | 32 | Address-phase pattern |
| cyc_be | output | 4 | Byte enables for the data phase |
| cyc_wdata | output | 32 | Write data for the data phase |
| cyc_done | input | 1 | Engine completion strobe |
| cyc_rdata | input | 32 | Engine read data (valid with done) |

## Verification
The acknowledge is due at a fixed number of cycles after the request:
- Address-port accesses, unclaimed accesses, disabled data-port accesses and master aborts are acknowledged in the first cycle after the request.
- A claimed data-port access raises cyc_start in that same first cycle, and is acknowledged one cycle after the engine's done.

The bench's engine model returns done after a chosen delay of zero to three cycles. Each host task counts the falling edges from the request to the acknowledge, and compares that count with the number these rules predict. It also captures the cycle fields on the falling edge where cyc_start is seen. Every output is sampled on falling edges, away from the edge where the registers update.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int unsigned CFGX_ADDR_W = 32;
    localparam int unsigned CFGX_BUS_W  = 8;
    localparam int unsigned CFGX_DEV_W  = 5;
    localparam int unsigned CFGX_FN_W   = 3;
    localparam int unsigned CFGX_REG_W  = 6;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RESP} cfgx_state_e;

    typedef struct packed {
        logic                  en;
        logic [CFGX_BUS_W-1:0] bus;
        logic [CFGX_DEV_W-1:0] dev;
        logic [CFGX_FN_W-1:0]  fn;
        logic [CFGX_REG_W-1:0] regno;
    } cfgx_sel_t;
endpackage

// File: rtl/cfgx_sel_reg.sv
module cfgx_sel_reg
    import cfgx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CFGX_ADDR_W-1:0] wr_data,
    output cfgx_sel_t              sel_o
);
    cfgx_sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (wr_en) begin
            sel_d.en    = wr_data[31];
            sel_d.bus   = wr_data[23:16];
            sel_d.dev   = wr_data[15:11];
            sel_d.fn    = wr_data[10:8];
            sel_d.regno = wr_data[7:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/cfgx_idsel_decode.sv
module cfgx_idsel_decode
    import cfgx_pkg::*;
#(
    parameter int unsigned IDSEL_LO = 11
) (
    input  logic [CFGX_DEV_W-1:0]  dev_i,
    output logic [CFGX_ADDR_W-1:0] idsel_o,
    output logic                   hit_o
);
    for (genvar g = 0; g < CFGX_ADDR_W; g++) begin : g_line
        if (g >= IDSEL_LO) begin : g_sel
            localparam int unsigned SLOT = g - IDSEL_LO;
            assign idsel_o[g] = (32'(dev_i) == SLOT);
        end else begin : g_low
            assign idsel_o[g] = 1'b0;
        end
    end

    assign hit_o = |idsel_o;
endmodule

// File: rtl/cfgx_phase_build.sv
module cfgx_phase_build
    import cfgx_pkg::*;
#(
    parameter int unsigned IDSEL_LO = 11
) (
    input  cfgx_sel_t              sel_i,
    input  logic [CFGX_BUS_W-1:0]  own_bus_i,
    input  logic                   wr_i,
    output logic [CFGX_ADDR_W-1:0] addr_o,
    output logic [3:0]             cmd_o,
    output logic                   abort_o
);
    logic [CFGX_ADDR_W-1:0] idsel;
    logic                   hit;
    logic                   local_bus;

    cfgx_idsel_decode #(.IDSEL_LO(IDSEL_LO)) u_dec (
        .dev_i   (sel_i.dev),
        .idsel_o (idsel),
        .hit_o   (hit)
    );

    always_comb begin
        local_bus = (sel_i.bus == own_bus_i);
        cmd_o     = wr_i ? CMD_CFG_WR : CMD_CFG_RD;
        if (local_bus) begin
            addr_o  = idsel | {{(CFGX_ADDR_W-11){1'b0}}, sel_i.fn, sel_i.regno, 2'b00};
            abort_o = !hit;
        end else begin
            addr_o  = {{(CFGX_ADDR_W-24){1'b0}}, sel_i.bus, sel_i.dev, sel_i.fn,
                       sel_i.regno, 2'b01};
            abort_o = 1'b0;
        end
    end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgx_pkg::*;
#(
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC,
    parameter int unsigned IDSEL_LO  = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bridge_bus,
    input  logic        host_req,
    input  logic        host_wr,
    input  logic [13:0] host_dw_addr,
    input  logic [3:0]  host_be,
    input  logic [31:0] host_wdata,
    output logic        host_ack,
    output logic        host_passthru,
    output logic [31:0] host_rdata,
    output logic        cyc_start,
    output logic [3:0]  cyc_cmd,
    output logic [31:0] cyc_addr,
    output logic [3:0]  cyc_be,
    output logic [31:0] cyc_wdata,
    input  logic        cyc_done,
    input  logic [31:0] cyc_rdata
);
    localparam logic [13:0] ADDR_DW = ADDR_PORT[15:2];
    localparam logic [13:0] DATA_DW = DATA_PORT[15:2];
    localparam logic [31:0] ALL_ONES = '1;

    typedef struct packed {
        cfgx_state_e st;
        logic        start;
        logic        pass;
        logic [31:0] rdata;
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
    } ctl_t;

    ctl_t      c_d, c_q;
    cfgx_sel_t sel;
    logic      idle_req, hit_aport, hit_dport, full_dw, sel_wr;
    logic [31:0] phase_addr, readback;
    logic [3:0]  phase_cmd;
    logic        phase_abort;

    cfgx_sel_reg u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_wr),
        .wr_data (host_wdata),
        .sel_o   (sel)
    );

    cfgx_phase_build #(.IDSEL_LO(IDSEL_LO)) u_build (
        .sel_i     (sel),
        .own_bus_i (bridge_bus),
        .wr_i      (host_wr),
        .addr_o    (phase_addr),
        .cmd_o     (phase_cmd),
        .abort_o   (phase_abort)
    );

    always_comb begin
        idle_req  = host_req && (c_q.st == ST_IDLE);
        hit_aport = (host_dw_addr == ADDR_DW);
        hit_dport = (host_dw_addr == DATA_DW);
        full_dw   = (host_be == 4'hF);
        sel_wr    = idle_req && host_wr && hit_aport && full_dw;
        readback  = {sel.en, 7'b0, sel.bus, sel.dev, sel.fn, sel.regno, 2'b00};

        c_d       = c_q;
        c_d.start = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (host_req) begin
                    c_d.st    = ST_RESP;
                    c_d.pass  = 1'b0;
                    c_d.rdata = '0;
                    if (hit_aport && full_dw) begin
                        c_d.rdata = host_wr ? '0 : readback;
                    end else if (hit_dport) begin
                        if (!sel.en || phase_abort) begin
                            c_d.rdata = host_wr ? '0 : ALL_ONES;
                        end else begin
                            c_d.st    = ST_RUN;
                            c_d.start = 1'b1;
                            c_d.cmd   = phase_cmd;
                            c_d.addr  = phase_addr;
                            c_d.be    = host_be;
                            c_d.wdata = host_wdata;
                        end
                    end else begin
                        c_d.pass = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (cyc_done) begin
                    c_d.st    = ST_RESP;
                    c_d.rdata = c_q.cmd[0] ? '0 : cyc_rdata;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign host_ack      = (c_q.st == ST_RESP);
    assign host_passthru = c_q.pass;
    assign host_rdata    = c_q.rdata;
    assign cyc_start     = c_q.start;
    assign cyc_cmd       = c_q.cmd;
    assign cyc_addr      = c_q.addr;
    assign cyc_be        = c_q.be;
    assign cyc_wdata     = c_q.wdata;

    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start);

    // R8
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_RUN && !cyc_done) |=>
            ($stable(cyc_addr) && $stable(cyc_cmd) && $stable(cyc_be) && $stable(cyc_wdata)));

    // R4
    idsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && cyc_addr[1:0] == 2'b00) |-> ($countones(cyc_addr[31:IDSEL_LO]) == 1));

    // R6
    cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> (cyc_cmd == CMD_CFG_RD || cyc_cmd == CMD_CFG_WR));

    // R3
    off_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && hit_dport && !sel.en) |=> (!cyc_start && host_ack));

    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
endmodule

// File: tb/tb_cfg_port_bridge.sv
module tb_cfg_port_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bridge_bus = 8'h00;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [13:0] host_dw_addr = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack, host_passthru, cyc_start, cyc_done = 1'b0;
    logic [31:0] host_rdata, cyc_addr, cyc_wdata, cyc_rdata = '0;
    logic [3:0]  cyc_cmd, cyc_be;

    localparam logic [13:0] AP = 14'h33E;
    localparam logic [13:0] DP = 14'h33F;

    int checks = 0, fails = 0, starts = 0, eng_lat = 2;
    logic [31:0] e_addr, e_wdata, eng_data = 32'hC0FF_EE01;
    logic [3:0]  e_cmd, e_be;
    logic        done_flag = 1'b0;

    cfg_port_bridge dut (.*);

    always #5 clk = ~clk;

    initial begin : engine
        forever begin
            @(negedge clk);
            if (cyc_start) begin
                starts++;
                e_addr = cyc_addr; e_cmd = cyc_cmd; e_be = cyc_be; e_wdata = cyc_wdata;
                repeat (eng_lat) @(negedge clk);
                cyc_done = 1'b1; cyc_rdata = eng_data;
                @(negedge clk);
                cyc_done = 1'b0; cyc_rdata = '0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_io(input logic wr, input logic [13:0] dw, input logic [3:0] be,
                           input logic [31:0] wd, output int lat, output logic [31:0] rd,
                           output logic pt);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_dw_addr = dw; host_be = be; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_ack && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        rd = host_rdata; pt = host_passthru;
    endtask

    function automatic logic [31:0] t0(input int dev, input int fn, input int rg);
        return (32'h1 << (11 + dev)) | 32'(fn << 8) | 32'(rg << 2);
    endfunction

    function automatic logic [31:0] sel_word(input int bus, input int dev, input int fn,
                                             input int rg);
        return 32'h8000_0000 | 32'(bus << 16) | 32'(dev << 11) | 32'(fn << 8) | 32'(rg << 2);
    endfunction

    task automatic t_reset();
        int l; logic [31:0] r; logic p;
        chk("R1 reset ack", {31'b0, host_ack}, 32'h0);
        chk("R8 reset start", {31'b0, cyc_start}, 32'h0);
        host_io(1'b0, AP, 4'hF, '0, l, r, p);
        chk("R1 reset selector", r, 32'h0);
        chk("R1 ack latency", 32'(l), 32'd1);
    endtask

    task automatic t_selector();
        int l; logic [31:0] r; logic p;
        host_io(1'b1, AP, 4'hF, 32'hFFFF_FFFF, l, r, p);
        chk("R1 write ack latency", 32'(l), 32'd1);
        host_io(1'b0, AP, 4'hF, '0, l, r, p);
        chk("R1 readback masks reserved", r, 32'h80FF_FFFC);
        chk("R1 not passthru", {31'b0, p}, 32'h0);
    endtask

    task automatic t_narrow();
        int l; logic [31:0] r; logic p; int s0;
        s0 = starts;
        host_io(1'b1, AP, 4'h1, 32'h0, l, r, p);
        chk("R2 narrow write passthru", {31'b0, p}, 32'h1);
        host_io(1'b0, AP, 4'hF, '0, l, r, p);
        chk("R2 selector unchanged", r, 32'h80FF_FFFC);
        host_io(1'b0, 14'h07C, 4'hF, '0, l, r, p);
        chk("R2 other port passthru", {31'b0, p}, 32'h1);
        chk("R2 no cycle", 32'(starts - s0), 32'd0);
    endtask

    task automatic t_disabled();
        int l; logic [31:0] r; logic p; int s0;
        host_io(1'b1, AP, 4'hF, sel_word(0, 3, 0, 0) & 32'h7FFF_FFFF, l, r, p);
        s0 = starts;
        host_io(1'b0, DP, 4'hF, '0, l, r, p);
        chk("R3 disabled read ones", r, 32'hFFFF_FFFF);
        chk("R3 disabled ack latency", 32'(l), 32'd1);
        host_io(1'b1, DP, 4'hF, 32'h1234_5678, l, r, p);
        chk("R3 disabled write no cycle", 32'(starts - s0), 32'd0);
    endtask

    task automatic t_type0_read();
        int l; logic [31:0] r; logic p;
        host_io(1'b1, AP, 4'hF, sel_word(0, 5, 2, 16), l, r, p);
        eng_lat = 2; eng_data = 32'hA5A5_0F0F;
        host_io(1'b0, DP, 4'hF, '0, l, r, p);
        chk("R4 type0 address", e_addr, t0(5, 2, 16));
        chk("R6 read command", {28'b0, e_cmd}, 32'hA);
        chk("R9 read data", r, 32'hA5A5_0F0F);
        chk("R9 ack latency lat2", 32'(l), 32'd4);
    endtask

    task automatic t_type0_write();
        int l; logic [31:0] r; logic p;
        host_io(1'b1, AP, 4'hF, sel_word(0, 0, 7, 63), l, r, p);
        eng_lat = 0;
        host_io(1'b1, DP, 4'h6, 32'hDEAD_BEEF, l, r, p);
        chk("R4 type0 dev0", e_addr, t0(0, 7, 63));
        chk("R6 write command", {28'b0, e_cmd}, 32'hB);
        chk("R8 byte enables", {28'b0, e_be}, 32'h6);
        chk("R8 write data", e_wdata, 32'hDEAD_BEEF);
        chk("R9 ack latency lat0", 32'(l), 32'd2);
        host_io(1'b1, AP, 4'hF, sel_word(0, 20, 1, 1), l, r, p);
        eng_lat = 3;
        host_io(1'b0, DP, 4'hF, '0, l, r, p);
        chk("R4 dev20 on top line", e_addr, t0(20, 1, 1));
        chk("R9 ack latency lat3", 32'(l), 32'd5);
    endtask

    task automatic t_abort();
        int l; logic [31:0] r; logic p; int s0;
        host_io(1'b1, AP, 4'hF, sel_word(0, 21, 0, 0), l, r, p);
        s0 = starts;
        host_io(1'b0, DP, 4'hF, '0, l, r, p);
        chk("R7 abort read ones", r, 32'hFFFF_FFFF);
        chk("R7 abort ack latency", 32'(l), 32'd1);
        host_io(1'b1, AP, 4'hF, sel_word(0, 31, 0, 0), l, r, p);
        host_io(1'b1, DP, 4'hF, 32'h1, l, r, p);
        chk("R7 abort no cycle", 32'(starts - s0), 32'd0);
    endtask

    task automatic t_type1();
        int l; logic [31:0] r; logic p; logic [31:0] w;
        w = sel_word(8'h05, 25, 6, 9);
        host_io(1'b1, AP, 4'hF, w, l, r, p);
        eng_lat = 1;
        host_io(1'b0, DP, 4'hF, '0, l, r, p);
        chk("R5 type1 address", e_addr, (w & 32'h00FF_FFFC) | 32'h1);
        chk("R7 type1 not aborted", {31'b0, p}, 32'h0);
        w = sel_word(8'h05, 4, 0, 2);
        host_io(1'b1, AP, 4'hF, w, l, r, p);
        bridge_bus = 8'h05;
        host_io(1'b1, DP, 4'hF, 32'h0, l, r, p);
        chk("R4 own bus match type0", e_addr, t0(4, 0, 2));
        bridge_bus = 8'h00;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_selector();
        t_narrow();
        t_disabled();
        t_type0_read();
        t_type0_write();
        t_abort();
        t_type1();
        repeat (3) @(negedge clk);
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule